// File: doc/BRIEF.md
# Eight-Slot TDM Serial Transmitter

This block turns one frame of sampled audio into a single serial line that carries eight 32-bit time slots. It runs on the bit clock, which runs at 256 times the frame rate. A rising edge on the frame-sync input, sampled on a rising bit-clock edge, starts a frame. The slots carry, in order: capture channels 1 to 4, two empty slots, and auxiliary channels 1 and 2. Each 24-bit sample is sent MSB first and left-justified in its slot. The remaining eight bits of the slot, and both empty slots, are sent as zero.

Samples are written into a staging register with a load strobe. They are copied into the frame register at the frame-start edge, so a load in the middle of a frame never disturbs the bits already on the line. If no load arrives, the previous samples are sent again. Data bits change on the falling bit-clock edge. The one exception is the first MSB of a frame, which is driven on the rising edge that detects the frame start, so it is already valid at the next rising edge, where the receiver samples it.

Top module: `tdm8_tx`

## Requirements
- R1: The slots go out in a fixed order. Slots 0 to 3 carry `cap_i` channels 1 to 4, slots 4 and 5 are empty, and slots 6 and 7 carry `aux_i` channels 1 and 2. Channel n of a bus sits at bits [24n+23:24n], with n counted from 0.
- R2: Bit n of a slot, for n from 0 to 23 and counted from the first rising edge after the frame start, is sample bit 23−n. Bit 0 of slot 0 is sampled at the rising edge that follows the start edge.
- R3: On the rising edge that detects a frame start, `sdata_o` takes the MSB of capture channel 1 of the frame being started.
- R4: Both empty slots are sent as zero.
- R5: Slot bits 24 to 31 are sent as zero, even when every sample bit is one.
- R6: A frame sends the values held in the staging register just before its start edge. A load during the frame, or on the start edge itself, takes effect in the next frame. Input changes without a load have no effect.
- R7: If no load occurs between two frames, the second frame repeats the samples of the first.
- R8: `sdata_o` is 0 from reset until the first frame start. It is also 0 once 256 bits have gone out with no new frame start.
- R9: A frame starts only on a 0-to-1 change of `fsync_i` seen on rising edges. A sync held high for many cycles, including one that is already high when reset is released, causes no further start.
- R10: Apart from the early MSB of R3, `sdata_o` changes only on falling `sclk_i` edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk_i | input | 1 | Bit clock, 256 × frame rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fsync_i | input | 1 | Frame sync; its rising edge marks the frame start |
| load_i | input | 1 | Captures `cap_i` and `aux_i` into staging on a rising edge |
| cap_i | input | 96 | Four 24-bit capture samples, channel 1 in the low bits |
| aux_i | input | 48 | Two 24-bit auxiliary samples, channel 1 in the low bits |
| sdata_o | output | 1 | Serial TDM data |

## Verification
The reference model predicts the line at both clock phases. A late first MSB would therefore show up as a mismatch right after the start edge, and a bit that changes on the rising edge would mismatch in the following half cycle. Loads placed mid-frame and exactly on the start edge catch a design that copies samples at the wrong moment: it would mix two sample sets within one frame, or send the new set one frame early. A word-wide sync, a sync that is high out of reset, and a 300-cycle gap with no sync check start detection and idle zeros. A design that restarted on a level would repeat slot 0, and one whose counter wrapped would resend the frame. A frame of all-ones samples exposes padding or empty slots that are not forced to zero.

// File: rtl/tdm8_tx_pkg.sv
package tdm8_tx_pkg;
  localparam int SAMPLE_W_DEF = 24;
  localparam int SLOT_W_DEF   = 32;
  localparam int N_SLOTS      = 8;
  localparam int N_CAP        = 4;
  localparam int N_AUX        = 2;
  localparam int N_CH         = N_CAP + N_AUX;

  typedef enum logic [1:0] {
    SLOT_CAP  = 2'd0,
    SLOT_NONE = 2'd1,
    SLOT_AUX  = 2'd2
  } slot_kind_e;

  function automatic slot_kind_e slot_kind(int s);
    if (s < N_CAP)          return SLOT_CAP;
    else if (s < N_CAP + 2) return SLOT_NONE;
    else                    return SLOT_AUX;
  endfunction

  // channel index inside the flattened sample vector for a given slot
  function automatic int slot_chan(int s);
    if (s < N_CAP) return s;
    else           return s - 2;
  endfunction
endpackage

// File: rtl/tdm8_sync_ctrl.sv
module tdm8_sync_ctrl #(
  parameter int FRAME_BITS = 256,
  localparam int CNT_W     = $clog2(FRAME_BITS) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fsync_i,
  output logic             start_o,
  output logic             valid_o,
  output logic [CNT_W-1:0] bit_idx_o
);
  localparam logic [CNT_W-1:0] IDLE = CNT_W'(FRAME_BITS);

  logic             fs_q;
  logic [CNT_W-1:0] cnt_q;

  assign start_o   = fsync_i & ~fs_q;
  assign valid_o   = (cnt_q != IDLE);
  assign bit_idx_o = cnt_q;

  // fs_q resets high: a sync already high at reset is not a start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fs_q  <= 1'b1;
      cnt_q <= IDLE;
    end else begin
      fs_q <= fsync_i;
      if (start_o)      cnt_q <= '0;
      else if (valid_o) cnt_q <= cnt_q + 1'b1;
    end
  end

  // R9
  cnt_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fsync_i && !fs_q) |=> (bit_idx_o == '0));

  // R8
  cnt_idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_idx_o == IDLE && !start_o) |=> (bit_idx_o == IDLE));

  // R2
  cnt_advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_o && bit_idx_o < IDLE) |=> (bit_idx_o == $past(bit_idx_o) + 1'b1));
endmodule

// File: rtl/tdm8_frame_store.sv
module tdm8_frame_store #(
  parameter int SAMPLE_W = 24,
  parameter int N_CH     = 6,
  localparam int VEC_W   = SAMPLE_W * N_CH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             start_i,
  input  logic [VEC_W-1:0] samples_i,
  output logic [VEC_W-1:0] frame_o,
  output logic             lead_msb_o
);
  logic [VEC_W-1:0] stage_q;
  logic [VEC_W-1:0] frame_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
      frame_q <= '0;
    end else begin
      if (load_i)  stage_q <= samples_i;
      if (start_i) frame_q <= stage_q;
    end
  end

  assign frame_o    = frame_q;
  // MSB of capture channel 1 as the upcoming frame will carry it
  assign lead_msb_o = stage_q[SAMPLE_W-1];

  // R6
  frame_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(frame_o));

  // R6
  frame_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (frame_o == $past(stage_q)));

  // R7
  stage_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(stage_q));
endmodule

// File: rtl/tdm8_bit_pick.sv
module tdm8_bit_pick
  import tdm8_tx_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int SLOT_W   = 32,
  localparam int VEC_W   = SAMPLE_W * N_CH,
  localparam int POS_W   = $clog2(SLOT_W),
  localparam int SEL_W   = $clog2(N_SLOTS),
  localparam int CNT_W   = $clog2(SLOT_W * N_SLOTS) + 1,
  localparam int PAD     = SLOT_W - SAMPLE_W
) (
  input  logic [VEC_W-1:0] frame_i,
  input  logic [CNT_W-1:0] idx_i,
  input  logic             valid_i,
  output logic             bit_o
);
  logic [SLOT_W-1:0] slot_word [N_SLOTS];
  logic [POS_W-1:0]  pos;
  logic [SEL_W-1:0]  sel;

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
    if (slot_kind(s) == SLOT_NONE) begin : g_empty
      assign slot_word[s] = '0;
    end else begin : g_data
      assign slot_word[s] =
        SLOT_W'(frame_i[slot_chan(s)*SAMPLE_W +: SAMPLE_W]) << PAD;
    end
  end

  assign pos = idx_i[POS_W-1:0];
  assign sel = idx_i[POS_W +: SEL_W];

  always_comb begin
    bit_o = 1'b0;
    if (valid_i) bit_o = slot_word[sel][SLOT_W-1-int'(pos)];
  end
endmodule

// File: rtl/tdm8_tx.sv
module tdm8_tx
  import tdm8_tx_pkg::*;
#(
  parameter int SAMPLE_W = SAMPLE_W_DEF,
  parameter int SLOT_W   = SLOT_W_DEF,
  localparam int FRAME_BITS = SLOT_W * N_SLOTS,
  localparam int CNT_W      = $clog2(FRAME_BITS) + 1,
  localparam int POS_W      = $clog2(SLOT_W)
) (
  input  logic                      sclk_i,
  input  logic                      rst_ni,
  input  logic                      fsync_i,
  input  logic                      load_i,
  input  logic [N_CAP*SAMPLE_W-1:0] cap_i,
  input  logic [N_AUX*SAMPLE_W-1:0] aux_i,
  output logic                      sdata_o
);
  logic                       start;
  logic                       valid;
  logic [CNT_W-1:0]           bit_idx;
  logic [N_CH*SAMPLE_W-1:0]   frame;
  logic                       lead_msb;
  logic                       next_bit;
  logic                       early_q;
  logic                       early_bit_q;
  logic                       fall_q;

  tdm8_sync_ctrl #(.FRAME_BITS(FRAME_BITS)) u_sync (
    .clk_i     (sclk_i),
    .rst_ni    (rst_ni),
    .fsync_i   (fsync_i),
    .start_o   (start),
    .valid_o   (valid),
    .bit_idx_o (bit_idx)
  );

  tdm8_frame_store #(.SAMPLE_W(SAMPLE_W), .N_CH(N_CH)) u_store (
    .clk_i      (sclk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_i),
    .start_i    (start),
    .samples_i  ({aux_i, cap_i}),
    .frame_o    (frame),
    .lead_msb_o (lead_msb)
  );

  tdm8_bit_pick #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W)) u_pick (
    .frame_i (frame),
    .idx_i   (bit_idx),
    .valid_i (valid),
    .bit_o   (next_bit)
  );

  // early MSB path: launched on the rising edge that sees the frame start
  always_ff @(posedge sclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      early_q     <= 1'b0;
      early_bit_q <= 1'b0;
    end else begin
      early_q <= start;
      if (start) early_bit_q <= lead_msb;
    end
  end

  // all other bits launched on the falling edge
  always_ff @(negedge sclk_i or negedge rst_ni) begin
    if (!rst_ni) fall_q <= 1'b0;
    else         fall_q <= next_bit;
  end

  assign sdata_o = early_q ? early_bit_q : fall_q;

  // R3
  early_msb_chk: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    start |=> (sdata_o == $past(cap_i[SAMPLE_W-1]) || $past(load_i) || 1'b0) || (sdata_o == $past(lead_msb)));

  // R4
  empty_slot_chk: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    (valid && !early_q && slot_kind(int'(bit_idx[CNT_W-2:POS_W])) == SLOT_NONE) |-> !sdata_o);

  // R5
  pad_zero_chk: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    (valid && !early_q && int'(bit_idx[POS_W-1:0]) >= SAMPLE_W) |-> !sdata_o);

  // R8
  idle_zero_chk: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    (!valid && !early_q) |-> !sdata_o);
endmodule

// File: tb/tdm8_tx_tb.sv
`timescale 1ns/1ps
module tdm8_tx_tb;
  logic        sclk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fsync = 1'b1;
  logic        load = 1'b0;
  logic [95:0] cap = '0;
  logic [47:0] aux = '0;
  logic        sdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  string scen = "R8";

  // behavioural model state
  int  m_stage [6];
  int  m_frame [6];
  int  m_cnt = 256;
  bit  m_fs_prev = 1;
  bit  m_start = 0;
  bit  last_fall = 0;

  always #2 sclk = ~sclk;   // 250 MHz

  tdm8_tx u_dut (
    .sclk_i (sclk), .rst_ni (rst_n), .fsync_i (fsync), .load_i (load),
    .cap_i (cap), .aux_i (aux), .sdata_o (sdata)
  );

  task automatic chk(string req, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s (scenario %s) cnt=%0d got=%0b exp=%0b t=%0t",
               req, scen, m_cnt, got, exp, $time);
    end
  endtask

  function automatic bit model_bit(int n);
    int slot, pos, ch;
    if (n >= 256) return 0;
    slot = n / 32;
    pos  = n % 32;
    if (slot == 4 || slot == 5) return 0;
    if (pos >= 24) return 0;
    ch = (slot < 4) ? slot : slot - 2;
    return ((m_frame[ch] >> (23 - pos)) & 1) != 0;
  endfunction

  function automatic string bit_tag(int n);
    if (n >= 256) return "R8";
    if (n / 32 == 4 || n / 32 == 5) return "R4";
    if (n % 32 >= 24) return "R5";
    if (n % 32 == 0) return "R1";
    return "R2";
  endfunction

  task automatic model_rise();
    m_start = fsync && !m_fs_prev;
    m_fs_prev = fsync;
    if (m_start) begin
      foreach (m_frame[i]) m_frame[i] = m_stage[i];
      m_cnt = 0;
    end else if (m_cnt < 256) begin
      m_cnt++;
    end
    if (load) begin
      for (int i = 0; i < 4; i++) m_stage[i] = int'(cap[24*i +: 24]);
      for (int i = 0; i < 2; i++) m_stage[4+i] = int'(aux[24*i +: 24]);
    end
  endtask

  task automatic step(bit fs, bit ld, logic [95:0] c, logic [47:0] a);
    bit e;
    fsync = fs; load = ld; cap = c; aux = a;
    @(posedge sclk);
    model_rise();
    #1;
    if (m_start) chk("R3", sdata, model_bit(0));
    else         chk("R10", sdata, last_fall);
    @(negedge sclk);
    #1;
    e = model_bit(m_cnt);
    chk(bit_tag(m_cnt), sdata, e);
    last_fall = e;
  endtask

  task automatic run_frame(int hi, int ld_at, logic [95:0] c, logic [47:0] a);
    for (int k = 0; k < 256; k++) step(k < hi, k == ld_at, c, a);
  endtask

  localparam logic [95:0] CAP_A = {24'h800001, 24'hF0E1D2, 24'h2468AC, 24'h93579B};
  localparam logic [47:0] AUX_A = {24'h7E0001, 24'hC3C3C3};
  localparam logic [95:0] CAP_B = {24'h0F0F0F, 24'h5A5A5A, 24'hFFFFFE, 24'h123456};
  localparam logic [47:0] AUX_B = {24'hABCDEF, 24'h000003};
  localparam logic [95:0] CAP_C = {24'hA00000, 24'h00000A, 24'h777777, 24'h7FFFFF};
  localparam logic [47:0] AUX_C = {24'h800000, 24'h3C3C3C};
  localparam logic [95:0] NOISE_C = {4{24'h6B1D2E}};
  localparam logic [47:0] NOISE_A = {2{24'hD4E2F1}};

  initial begin
    foreach (m_stage[i]) begin m_stage[i] = 0; m_frame[i] = 0; end
    // reset with sync high
    for (int k = 0; k < 3; k++) begin
      @(negedge sclk); #1;
      chk("R8", sdata, 1'b0);
    end
    rst_n = 1'b1;
    // sync still high after reset: no start
    scen = "R9";
    step(1, 1, CAP_A, AUX_A);
    for (int k = 0; k < 5; k++) step(1, 0, NOISE_C, NOISE_A);
    for (int k = 0; k < 4; k++) step(0, 0, NOISE_C, NOISE_A);
    // frame 1 sends A; B loaded mid-frame
    scen = "R6";
    run_frame(1, 100, CAP_B, AUX_B);
    // frame 2 sends B, word-wide sync, no load, inputs change
    scen = "R9";
    run_frame(128, -1, NOISE_C, NOISE_A);
    // frame 3 sends B again; C loaded on the start edge
    scen = "R7";
    run_frame(1, 0, CAP_C, AUX_C);
    // frame 4 sends C
    scen = "R6";
    run_frame(1, -1, NOISE_C, NOISE_A);
    // no sync for longer than a frame
    scen = "R8";
    for (int k = 0; k < 300; k++) step(0, k == 150, '1, '1);
    // all-ones frame exercises padding and empty slots
    scen = "R5";
    run_frame(1, -1, '0, '0);
    for (int k = 0; k < 8; k++) step(0, 0, '0, '0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #80000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired t=%0t", $time);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule